// File: doc/BRIEF.md
# Program Counter Sequencer

This block keeps the 13-bit fetch address of a small 8-bit controller. The controller has 16-bit instruction words and an 8K-word program space. Each clock cycle it takes decoded control strobes from the instruction decoder and picks the next address from one of several sources:

- a plain increment;
- an absolute jump;
- a subroutine call or return through an eight-entry hardware return stack;
- interrupt entry to a fixed vector;
- a computed jump that adds the accumulator to the low byte of the counter;
- a computed step that subtracts the accumulator from the low byte.

The add form carries into the high part of the counter. The subtract form never borrows from it.

The block also holds a one-level shadow copy of the accumulator and the flag byte for interrupt handlers. The restore never alters the two reset-cause flag bits. A sticky overflow flag records that the return stack has wrapped. A one-cycle pulse tells the interrupt controller to re-enable global interrupts after a return-from-interrupt.

Top module: `pcseq_unit`

## Requirements
- R1: A synchronous active-high reset sets `pc_o` to 0000h and clears `ovf_o`, `gie_set_o` and `rs_vld_o`.
- R2: `adv_i` on its own makes `pc_o` one greater at the next edge, and 1FFFh wraps to 0000h. With no strobe raised, `pc_o` holds its value.
- R3: `jmp_i` loads `tgt_i` into `pc_o`. `call_i` pushes the address after the current one (`pc_o`+1, wrapping) onto the return stack and loads `tgt_i`.
- R4: `ret_i` pops the top stack entry into `pc_o`. `reti_i` does the same and raises `gie_set_o` for exactly the one cycle in which the popped address appears.
- R5: `irq_ack_i` loads 0008h and pushes one entry. That entry is `tgt_i` if `jmp_i` or `call_i` is raised in the same cycle, and `pc_o` otherwise. Every other address strobe in that cycle is ignored.
- R6: `addpc_i` sets bits [7:0] of the counter to the low byte of bits [7:0] + `acc_i`. A carry out of bit 7 adds one to bits [12:8], which wrap modulo 32.
- R7: `subpc_i` sets bits [7:0] to bits [7:0] − `acc_i` modulo 256 and leaves bits [12:8] unchanged, even when the subtraction borrows.
- R8: The return stack is last-in first-out across up to 8 nested pushes.
- R9: A push while 8 entries are held overwrites the oldest entry in circular order and sets `ovf_o`. `ovf_o` stays set until reset.
- R10: A pop from an empty stack returns the entry just below the write position and leaves the stack position unchanged.
- R11: `save_i` stores `acc_i` and `flags_i[5:0]`. One cycle after `restore_i`:
  - `rs_vld_o` is high;
  - `rs_acc_o` and `rs_flg_o[5:0]` show the stored values from before any save in the same cycle;
  - `rs_flg_o[7:6]` equal the `flags_i[7:6]` reset-cause bits present at the restore.
- R12: The address strobes take effect in this priority: `irq_ack_i`, `jmp_i`, `call_i`, `ret_i`, `reti_i`, `addpc_i`, `subpc_i`, `adv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Sequential increment |
| jmp_i | input | 1 | Absolute jump to `tgt_i` |
| call_i | input | 1 | Call `tgt_i`, push return address |
| ret_i | input | 1 | Return from subroutine |
| reti_i | input | 1 | Return from interrupt |
| addpc_i | input | 1 | Low byte plus accumulator, with carry |
| subpc_i | input | 1 | Low byte minus accumulator, no borrow |
| irq_ack_i | input | 1 | Interrupt accepted this cycle |
| save_i | input | 1 | Store accumulator and flags in shadow |
| restore_i | input | 1 | Read shadow back |
| tgt_i | input | 13 | Immediate target address |
| acc_i | input | 8 | Accumulator value |
| flags_i | input | 8 | Flag byte, bits [7:6] reset cause |
| pc_o | output | 13 | Program counter |
| gie_set_o | output | 1 | Re-enable global interrupts pulse |
| ovf_o | output | 1 | Sticky return-stack overflow |
| rs_vld_o | output | 1 | Restored values valid |
| rs_acc_o | output | 8 | Restored accumulator |
| rs_flg_o | output | 8 | Restored flags |

## Verification
The bound checker watches the following on every cycle:
- the reset value;
- the interrupt vector;
- the plain increment;
- the no-borrow rule of the subtract step;
- stickiness of the overflow flag;
- the one-cycle relation between a return-from-interrupt or restore strobe and its pulse.

Only the bench scenarios can show what depends on history. That covers stack ordering across nested calls, the circular overwrite after the ninth push, the value returned by a pop on an empty stack, the same-cycle interrupt-versus-call case, and the shadow contents across save and restore.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Address source chosen for the next cycle
  typedef enum logic [3:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_JMP,
    SRC_CALL,
    SRC_RET,
    SRC_RETI,
    SRC_ADD,
    SRC_SUB,
    SRC_IRQ
  } pc_src_e;

endpackage

// File: rtl/pcseq_sel.sv
module pcseq_sel
  import pcseq_pkg::*;
#(
  parameter int PC_W = 13
) (
  input  logic            adv_i,
  input  logic            jmp_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            addpc_i,
  input  logic            subpc_i,
  input  logic            irq_ack_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] tgt_i,
  output pc_src_e         src_o,
  output logic            push_o,
  output logic            pop_o,
  output logic [PC_W-1:0] push_val_o
);

  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  // Fixed priority; interrupt entry overrides everything
  always_comb begin
    src_o      = SRC_HOLD;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    push_val_o = pc_i;
    if (irq_ack_i) begin
      src_o      = SRC_IRQ;
      push_o     = 1'b1;
      push_val_o = (jmp_i || call_i) ? tgt_i : pc_i;
    end else if (jmp_i) begin
      src_o = SRC_JMP;
    end else if (call_i) begin
      src_o      = SRC_CALL;
      push_o     = 1'b1;
      push_val_o = pc_i + ONE;
    end else if (ret_i) begin
      src_o = SRC_RET;
      pop_o = 1'b1;
    end else if (reti_i) begin
      src_o = SRC_RETI;
      pop_o = 1'b1;
    end else if (addpc_i) begin
      src_o = SRC_ADD;
    end else if (subpc_i) begin
      src_o = SRC_SUB;
    end else if (adv_i) begin
      src_o = SRC_INC;
    end
  end

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              DATA_W  = 8,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0008
) (
  input  pc_src_e           src_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   tgt_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [PC_W-1:0]   pop_data_i,
  output logic [PC_W-1:0]   next_o
);

  localparam int PCH_W = PC_W - DATA_W;
  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [DATA_W:0]     sum;
  logic [DATA_W-1:0]   diff;
  logic [PCH_W-1:0]    pch_up;

  always_comb begin
    sum    = {1'b0, pc_i[DATA_W-1:0]} + {1'b0, acc_i};
    diff   = pc_i[DATA_W-1:0] - acc_i;
    pch_up = pc_i[PC_W-1:DATA_W] + {{(PCH_W-1){1'b0}}, sum[DATA_W]};
    unique case (src_i)
      SRC_INC:            next_o = pc_i + ONE;
      SRC_JMP, SRC_CALL:  next_o = tgt_i;
      SRC_RET, SRC_RETI:  next_o = pop_data_i;
      SRC_ADD:            next_o = {pch_up, sum[DATA_W-1:0]};
      SRC_SUB:            next_o = {pc_i[PC_W-1:DATA_W], diff};
      SRC_IRQ:            next_o = IRQ_VEC;
      default:            next_o = pc_i;
    endcase
  end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_val_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic             ovf_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [PTR_W-1:0] rd_idx;
  logic [PTR_W-1:0] wp_inc;

  assign rd_idx     = (wp_q == '0) ? LAST : wp_q - 1'b1;
  assign wp_inc     = (wp_q == LAST) ? '0 : wp_q + 1'b1;
  assign pop_data_o = mem[rd_idx];
  assign ovf_o      = ovf_q;

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= push_val_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (push_i) begin
      wp_q <= wp_inc;
      if (cnt_q == FULL) ovf_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      wp_q  <= rd_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/pcseq_shadow.sv
module pcseq_shadow #(
  parameter int DATA_W = 8,
  parameter int KEEP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic              rs_vld_o,
  output logic [DATA_W-1:0] rs_acc_o,
  output logic [DATA_W-1:0] rs_flg_o
);

  localparam int SAVE_W = DATA_W - KEEP_W;

  logic [DATA_W-1:0] acc_buf;
  logic [SAVE_W-1:0] flg_buf;
  logic [DATA_W-1:0] flg_view;

  generate
    if (KEEP_W == 0) begin : g_all
      assign flg_view = flg_buf;
    end else begin : g_keep
      assign flg_view = {flags_i[DATA_W-1:SAVE_W], flg_buf};
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_buf  <= '0;
      flg_buf  <= '0;
      rs_vld_o <= 1'b0;
      rs_acc_o <= '0;
      rs_flg_o <= '0;
    end else begin
      rs_vld_o <= restore_i;
      if (restore_i) begin
        rs_acc_o <= acc_buf;
        rs_flg_o <= flg_view;
      end
      if (save_i) begin
        acc_buf <= acc_i;
        flg_buf <= flags_i[SAVE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
  import pcseq_pkg::*;
#(
  parameter int              PC_W        = 13,
  parameter int              DATA_W      = 8,
  parameter int              STACK_DEPTH = 8,
  parameter int              KEEP_W      = 2,
  parameter logic [PC_W-1:0] RST_VEC     = 13'h0000,
  parameter logic [PC_W-1:0] IRQ_VEC     = 13'h0008
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              reti_i,
  input  logic              addpc_i,
  input  logic              subpc_i,
  input  logic              irq_ack_i,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic [PC_W-1:0]   tgt_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              gie_set_o,
  output logic              ovf_o,
  output logic              rs_vld_o,
  output logic [DATA_W-1:0] rs_acc_o,
  output logic [DATA_W-1:0] rs_flg_o
);

  pc_src_e         src;
  logic            push, pop;
  logic [PC_W-1:0] push_val, pop_data, next_pc, pc_q;

  pcseq_sel #(.PC_W(PC_W)) u_sel (
    .adv_i, .jmp_i, .call_i, .ret_i, .reti_i, .addpc_i, .subpc_i, .irq_ack_i,
    .pc_i(pc_q), .tgt_i, .src_o(src), .push_o(push), .pop_o(pop),
    .push_val_o(push_val)
  );

  pcseq_stack #(.WIDTH(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk_i, .rst_i, .push_i(push), .pop_i(pop), .push_val_i(push_val),
    .pop_data_o(pop_data), .ovf_o
  );

  pcseq_next #(.PC_W(PC_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)) u_next (
    .src_i(src), .pc_i(pc_q), .tgt_i, .acc_i, .pop_data_i(pop_data),
    .next_o(next_pc)
  );

  pcseq_shadow #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_shadow (
    .clk_i, .rst_i, .save_i, .restore_i, .acc_i, .flags_i,
    .rs_vld_o, .rs_acc_o, .rs_flg_o
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_q      <= RST_VEC;
      gie_set_o <= 1'b0;
    end else begin
      pc_q      <= next_pc;
      gie_set_o <= (src == SRC_RETI);
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int              PC_W    = 13,
  parameter int              DATA_W  = 8,
  parameter logic [PC_W-1:0] RST_VEC = 13'h0000,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0008
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              adv_i,
  input logic              jmp_i,
  input logic              call_i,
  input logic              ret_i,
  input logic              reti_i,
  input logic              addpc_i,
  input logic              subpc_i,
  input logic              irq_ack_i,
  input logic              save_i,
  input logic              restore_i,
  input logic [PC_W-1:0]   tgt_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] flags_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              gie_set_o,
  input logic              ovf_o,
  input logic              rs_vld_o,
  input logic [DATA_W-1:0] rs_acc_o,
  input logic [DATA_W-1:0] rs_flg_o
);

  logic armed = 1'b0;
  always_ff @(posedge clk_i) armed <= armed | rst_i;

  logic only_adv, only_sub;
  assign only_adv = adv_i && !(jmp_i || call_i || ret_i || reti_i ||
                               addpc_i || subpc_i || irq_ack_i);
  assign only_sub = subpc_i && !(jmp_i || call_i || ret_i || reti_i ||
                                 addpc_i || irq_ack_i);

  p_reset_pc_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && $past(rst_i)) |-> (pc_o == RST_VEC && !ovf_o));

  p_increment_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && !$past(rst_i) && $past(only_adv)) |-> (pc_o == $past(pc_o) + 1'b1));

  p_irq_vector_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && !$past(rst_i) && $past(irq_ack_i)) |-> (pc_o == IRQ_VEC));

  p_no_borrow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && !$past(rst_i) && $past(only_sub)) |->
      (pc_o[PC_W-1:DATA_W] == $past(pc_o[PC_W-1:DATA_W])));

  p_no_overflow_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && !$past(rst_i) && $past(ovf_o)) |-> ovf_o);

  p_gie_pulse_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && gie_set_o) |-> ($past(reti_i) && !$past(rst_i)));

  p_restore_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && !$past(rst_i)) |-> (rs_vld_o == $past(restore_i)));

endmodule

bind pcseq_unit pcseq_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (.*);

// File: tb/sim_pcseq_unit.sv
module sim_pcseq_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        adv, jmp, call, ret, reti, addpc, subpc, irq, save, restore;
  logic [12:0] tgt;
  logic [7:0]  acc, flags;
  logic [12:0] pc;
  logic        gie, ovf, rs_vld;
  logic [7:0]  rs_acc, rs_flg;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  int          m_wp, m_cnt;
  bit          m_ovf;
  logic [7:0]  m_sacc;
  logic [5:0]  m_sflg;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcseq_unit u0 (
    .clk_i(clk), .rst_i(rst), .adv_i(adv), .jmp_i(jmp), .call_i(call),
    .ret_i(ret), .reti_i(reti), .addpc_i(addpc), .subpc_i(subpc),
    .irq_ack_i(irq), .save_i(save), .restore_i(restore), .tgt_i(tgt),
    .acc_i(acc), .flags_i(flags), .pc_o(pc), .gie_set_o(gie), .ovf_o(ovf),
    .rs_vld_o(rs_vld), .rs_acc_o(rs_acc), .rs_flg_o(rs_flg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] add_pc(input logic [12:0] p, input logic [7:0] a);
    logic [8:0] s;
    s = {1'b0, p[7:0]} + {1'b0, a};
    return {p[12:8] + {4'b0, s[8]}, s[7:0]};
  endfunction

  // s bits: 0 adv,1 jmp,2 call,3 ret,4 reti,5 add,6 sub,7 irq
  task automatic step(input logic [7:0] s, input logic [12:0] t, input logic [7:0] a,
                      input logic [7:0] f, input bit sv, input bit rs, input string otag);
    logic [12:0] np, pv;
    bit          push, pop, g;
    int          idx;
    string       tag;
    logic [7:0]  e_acc, e_flg;
    @(negedge clk);
    {irq, subpc, addpc, reti, ret, call, jmp, adv} = s;
    tgt = t; acc = a; flags = f; save = sv; restore = rs;
    np = m_pc; push = 0; pop = 0; g = 0; pv = m_pc; tag = "R2";
    if (s[7]) begin push = 1; pv = (s[1] || s[2]) ? t : m_pc; np = 13'h008; tag = "R5"; end
    else if (s[1]) begin np = t; tag = "R3"; end
    else if (s[2]) begin push = 1; pv = m_pc + 13'd1; np = t; tag = "R3"; end
    else if (s[3]) begin pop = 1; tag = "R4"; end
    else if (s[4]) begin pop = 1; g = 1; tag = "R4"; end
    else if (s[5]) begin np = add_pc(m_pc, a); tag = "R6"; end
    else if (s[6]) begin np = {m_pc[12:8], m_pc[7:0] - a}; tag = "R7"; end
    else if (s[0]) begin np = m_pc + 13'd1; tag = "R2"; end
    if (pop) begin
      idx = (m_wp == 0) ? 7 : m_wp - 1;
      np = m_stk[idx];
      if (m_cnt > 0) begin m_wp = idx; m_cnt--; end
    end
    if (push) begin
      m_stk[m_wp] = pv;
      m_wp = (m_wp + 1) % 8;
      if (m_cnt == 8) m_ovf = 1; else m_cnt++;
    end
    e_acc = m_sacc; e_flg = {f[7:6], m_sflg};
    if (sv) begin m_sacc = a; m_sflg = f[5:0]; end
    m_pc = np;
    if (otag != "") tag = otag;
    @(posedge clk); #1;
    chk(tag, pc, np);
    chk("R4 gie", gie, g);
    chk("R9 ovf", ovf, m_ovf);
    chk("R11 vld", rs_vld, rs);
    if (rs) begin
      chk("R11 acc", rs_acc, e_acc);
      chk("R11 flg", rs_flg, e_flg);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    {irq, subpc, addpc, reti, ret, call, jmp, adv, save, restore} = '0;
    tgt = '0; acc = '0; flags = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    m_pc = '0; m_wp = 0; m_cnt = 0; m_ovf = 0; m_sacc = '0; m_sflg = '0;
    #1;
    chk("R1 pc", pc, 0); chk("R1 ovf", ovf, 0);
    chk("R1 gie", gie, 0); chk("R1 vld", rs_vld, 0);

    // R2 increment, hold, and wrap
    step(8'h01, 0, 0, 0, 0, 0, "R2");
    step(8'h00, 0, 0, 0, 0, 0, "R2");
    step(8'h02, 13'h1FFF, 0, 0, 0, 0, "R3");
    step(8'h01, 0, 0, 0, 0, 0, "R2");
    chk("R2 wrap", pc, 0);

    // R8/R9 nine calls, overwrite oldest
    for (int i = 0; i < 9; i++) step(8'h04, 13'h100 + 13'(i), 0, 0, 0, 0, "R3");
    chk("R9 sticky", ovf, 1);
    for (int i = 0; i < 8; i++) step(8'h08, 0, 0, 0, 0, 0, "R8");
    // R10 empty pop returns entry below write position
    step(8'h08, 0, 0, 0, 0, 0, "R10");
    step(8'h10, 0, 0, 0, 0, 0, "R10");

    // R6 carry into high part, R7 no borrow
    step(8'h02, 13'h02F0, 0, 0, 0, 0, "R3");
    step(8'h20, 0, 8'h20, 0, 0, 0, "R6");
    chk("R6 carry", pc, 13'h0310);
    step(8'h40, 0, 8'h20, 0, 0, 0, "R7");
    chk("R7 borrow", pc, 13'h03F0);
    step(8'h02, 13'h1FF0, 0, 0, 0, 0, "R3");
    step(8'h20, 0, 8'h10, 0, 0, 0, "R6");
    chk("R6 wrap", pc, 13'h0000);

    // R12 priority, R5 irq with call
    step(8'h61, 0, 8'h05, 0, 0, 0, "R12");
    step(8'h84, 13'h0ABC, 0, 0, 0, 0, "R5");
    step(8'h10, 0, 0, 0, 0, 0, "R5");
    chk("R5 resume", pc, 13'h0ABC);

    // R11 shadow keeps reset-cause bits
    step(8'h00, 0, 8'hA5, 8'hFF, 1, 0, "R11");
    step(8'h00, 0, 8'h11, 8'h00, 1, 1, "R11");
    step(8'h00, 0, 8'h00, 8'hC0, 0, 1, "R11");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] s;
      s = 8'($urandom) & 8'($urandom) & 8'($urandom);
      step(s, 13'($urandom), 8'($urandom), 8'($urandom),
           bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 3) == 0), "");
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 pc", pc, 0); chk("R1 ovf", ovf, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule